// File: doc/BRIEF.md
# Protected Memory Region Lock Unit

This block guards a private memory window that belongs to a privileged handler mode. It holds three configuration values: the entry address of the handler code, the base address of the guarded window, and a mask register. The mask register carries the window's size mask and two control bits. A separate lock bit makes all three values read-only once firmware has finished setting them up, so the window cannot later be moved or switched off.

A 64-bit write-only key gives a controlled way to release the lock. Firmware loads the key while the lock is still clear. After the lock is set, writing the same value again releases it, and any other value is refused and raises a one-cycle mismatch pulse.

The block has two ports. A register port, tagged with a privilege flag, is used for configuration. A combinational check port takes an address, a privilege flag and a read/write indication. It returns deny or allow, and it replaces the data of a denied read with all-ones. A status output flags a handler entry address that lies outside the active window.

Top module: `prot_region_lock`

## Requirements
- R1: After reset the handler base, region base and mask registers read as zero, the lock is clear, no key is armed, and the check port allows every access.
- R2: Register writes with the privilege flag low are ignored. Register reads with the privilege flag low return zero. Register selects are: 0 handler base, 1 region base, 2 region mask, 3 lock (bit 0), 4 key.
- R3: While the lock is set, writes to the handler base, region base and mask registers leave them unchanged.
- R4: Protection is active only when mask bits [1:0] are both 1. An address hits the window when (addr & L) == (base & L), where L is the mask with bits [1:0] forced to zero. A non-privileged access that hits an active window is denied. Privileged accesses, misses and accesses while protection is inactive are allowed.
- R5: A denied read returns all-ones on the check port's data output. Every other access passes the memory data through unchanged.
- R6: A key write while the lock is clear stores the 64-bit value and arms the key. Reads of the key select return zero.
- R7: With the lock set and the key armed, a key write equal to the stored key clears the lock at that clock edge.
- R8: With the lock set, a key write that does not match, or any key write when no key is armed, leaves the lock set and raises the mismatch output for exactly the following cycle.
- R9: Writing 1 to lock bit 0 sets the lock. Writing 0 to it never clears the lock.
- R10: The handler-outside flag is high exactly when protection is active and the handler base misses the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_priv_i | input | 1 | Register access is privileged |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data |
| chk_addr_i | input | AW | Address to check |
| chk_priv_i | input | 1 | Checked access is privileged |
| chk_read_i | input | 1 | Checked access is a read |
| chk_mem_rdata_i | input | DW | Data from the memory for the checked read |
| chk_deny_o | output | 1 | Access is denied |
| chk_rdata_o | output | DW | Read data after substitution |
| lock_o | output | 1 | Lock bit state |
| key_miss_o | output | 1 | One-cycle pulse on a refused key write |
| hdl_outside_o | output | 1 | Handler base lies outside the active window |

## Verification
The bench tries to relocate or disable a locked window by writing base and mask and by writing zero to the lock bit. A design with a leaky freeze would start allowing hits through. It checks that protection needs both control bits set, so a design that tests only one bit would keep denying after bit 1 is cleared. On the key path it covers a wrong key, a key write with no key armed, and a re-key attempt while locked. A design that stores the key regardless of the lock would let an attacker pick their own unlock value. It also probes addresses just inside and just outside the window edge, and checks that a denied write does not corrupt the pass-through data.

// File: rtl/prl_pkg.sv
package prl_pkg;
  localparam logic [2:0] SEL_HDL   = 3'd0;
  localparam logic [2:0] SEL_RBASE = 3'd1;
  localparam logic [2:0] SEL_RMASK = 3'd2;
  localparam logic [2:0] SEL_LOCK  = 3'd3;
  localparam logic [2:0] SEL_KEY   = 3'd4;
endpackage

// File: rtl/prl_region_match.sv
module prl_region_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] lim_i,
  output logic          hit_o
);
  assign hit_o = ((addr_i & lim_i) == (base_i & lim_i));
endmodule

// File: rtl/prl_cfg_regs.sv
module prl_cfg_regs
  import prl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          clr_lock_i,
  output logic [AW-1:0] hdl_q_o,
  output logic [AW-1:0] rbase_q_o,
  output logic [AW-1:0] rmask_q_o,
  output logic          lock_q_o
);
  logic open_wr;
  assign open_wr = wr_i && !lock_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdl_q_o   <= '0;
      rbase_q_o <= '0;
      rmask_q_o <= '0;
      lock_q_o  <= 1'b0;
    end else begin
      if (open_wr && sel_i == SEL_HDL)   hdl_q_o   <= wdata_i;
      if (open_wr && sel_i == SEL_RBASE) rbase_q_o <= wdata_i;
      if (open_wr && sel_i == SEL_RMASK) rmask_q_o <= wdata_i;
      if (clr_lock_i)                       lock_q_o <= 1'b0;
      else if (wr_i && sel_i == SEL_LOCK)   lock_q_o <= lock_q_o | wdata_i[0];
    end
  end

  // frozen while locked
  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q_o |=> ($stable(hdl_q_o) && $stable(rbase_q_o) && $stable(rmask_q_o)));

  // zero write never releases lock
  p_no_soft_unlock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q_o && !clr_lock_i) |=> lock_q_o);
endmodule

// File: rtl/prl_key_unit.sv
module prl_key_unit #(
  parameter int KW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_wr_i,
  input  logic [KW-1:0] wdata_i,
  input  logic          lock_i,
  output logic          clr_lock_o,
  output logic          miss_o
);
  logic [KW-1:0] key_q;
  logic          armed_q;
  logic          match;

  assign match      = armed_q && (wdata_i == key_q);
  assign clr_lock_o = key_wr_i && lock_i && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      armed_q <= 1'b0;
      miss_o  <= 1'b0;
    end else begin
      miss_o <= key_wr_i && lock_i && !match;
      if (key_wr_i && !lock_i) begin
        key_q   <= wdata_i;
        armed_q <= 1'b1;
      end
    end
  end

  // key is only loaded while unlocked
  p_key_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(key_q));

  p_unlock_needs_arm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_lock_o |-> armed_q);
endmodule

// File: rtl/prot_region_lock.sv
module prot_region_lock
  import prl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int KW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_priv_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [AW-1:0] chk_addr_i,
  input  logic          chk_priv_i,
  input  logic          chk_read_i,
  input  logic [DW-1:0] chk_mem_rdata_i,
  output logic          chk_deny_o,
  output logic [DW-1:0] chk_rdata_o,
  output logic          lock_o,
  output logic          key_miss_o,
  output logic          hdl_outside_o
);
  localparam int NCHK = 2;

  logic          wr;
  logic          clr_lock;
  logic [AW-1:0] hdl_q, rbase_q, rmask_q, lim;
  logic          active;
  logic [AW-1:0] probe [NCHK];
  logic [NCHK-1:0] hit;

  assign wr = reg_we_i && reg_priv_i;

  prl_cfg_regs #(.AW(AW)) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i[AW-1:0]), .clr_lock_i(clr_lock),
    .hdl_q_o(hdl_q), .rbase_q_o(rbase_q), .rmask_q_o(rmask_q), .lock_q_o(lock_o)
  );

  prl_key_unit #(.KW(KW)) i_key (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(wr && reg_sel_i == SEL_KEY),
    .wdata_i(reg_wdata_i[KW-1:0]), .lock_i(lock_o),
    .clr_lock_o(clr_lock), .miss_o(key_miss_o)
  );

  assign active   = &rmask_q[1:0];
  assign lim      = {rmask_q[AW-1:2], 2'b00};
  assign probe[0] = chk_addr_i;
  assign probe[1] = hdl_q;

  for (genvar g = 0; g < NCHK; g++) begin : g_match
    prl_region_match #(.AW(AW)) i_match (
      .addr_i(probe[g]), .base_i(rbase_q), .lim_i(lim), .hit_o(hit[g])
    );
  end

  assign chk_deny_o    = active && hit[0] && !chk_priv_i;
  assign chk_rdata_o   = (chk_deny_o && chk_read_i) ? '1 : chk_mem_rdata_i;
  assign hdl_outside_o = active && !hit[1];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_priv_i) begin
      case (reg_sel_i)
        SEL_HDL:   reg_rdata_o = DW'(hdl_q);
        SEL_RBASE: reg_rdata_o = DW'(rbase_q);
        SEL_RMASK: reg_rdata_o = DW'(rmask_q);
        SEL_LOCK:  reg_rdata_o = DW'(lock_o);
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  p_priv_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_priv_i |-> !chk_deny_o);

  p_inactive_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rmask_q[0] && rmask_q[1]) |-> !chk_deny_o);

  p_fill_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_deny_o && chk_read_i) |-> (&chk_rdata_o));

  p_miss_keeps_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_miss_o |-> (lock_o && $stable(lock_o)));

  p_unlock_by_key_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(reg_we_i && reg_priv_i && reg_sel_i == SEL_KEY));

  p_key_reads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == SEL_KEY) |-> (reg_rdata_o == '0));
endmodule

// File: tb/test_prot_region_lock.sv
module test_prot_region_lock;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0, reg_priv_i = 1'b0;
  logic [2:0]    reg_sel_i = '0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic [AW-1:0] chk_addr_i = '0;
  logic          chk_priv_i = 1'b0, chk_read_i = 1'b0;
  logic [DW-1:0] chk_mem_rdata_i = 64'h1234_5678_9ABC_DEF0;
  logic          chk_deny_o;
  logic [DW-1:0] chk_rdata_o;
  logic          lock_o, key_miss_o, hdl_outside_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [63:0] KEY_A = 64'h5EC2_E7C0_DE00_0A5A;
  localparam logic [63:0] MEM   = 64'h1234_5678_9ABC_DEF0;

  prot_region_lock #(.AW(AW), .DW(DW), .KW(64)) i_prot_region_lock (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [63:0] d, input logic priv);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d; reg_priv_i = priv;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_priv_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic priv, output logic [63:0] d);
    reg_sel_i = sel; reg_priv_i = priv;
    #1 d = reg_rdata_o;
    reg_priv_i = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic priv, input logic rd_n);
    chk_addr_i = a; chk_priv_i = priv; chk_read_i = rd_n;
    #1;
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      rd(3'(s), 1'b1, d);
      expect_eq("R1 reg zero", d, 64'h0);
    end
    expect_eq("R1 lock clear", 64'(lock_o), 64'h0);
    probe(32'h0, 1'b0, 1'b1);
    expect_eq("R1 no deny", 64'(chk_deny_o), 64'h0);
    expect_eq("R1 outside flag", 64'(hdl_outside_o), 64'h0);
  endtask

  task automatic t_priv_port;
    logic [63:0] d;
    wr(3'd1, 64'h00AB_0000, 1'b0);
    rd(3'd1, 1'b1, d);
    expect_eq("R2 unpriv write ignored", d, 64'h0);
    wr(3'd1, 64'h0010_0000, 1'b1);
    rd(3'd1, 1'b0, d);
    expect_eq("R2 unpriv read zero", d, 64'h0);
    rd(3'd1, 1'b1, d);
    expect_eq("R2 priv read", d, 64'h0010_0000);
  endtask

  task automatic t_region;
    logic [63:0] d;
    wr(3'd0, 64'h0010_8000, 1'b1);
    wr(3'd2, 64'hFFF0_0003, 1'b1);
    rd(3'd2, 1'b1, d);
    expect_eq("R2 mask read", d, 64'hFFF0_0003);
    probe(32'h0012_3456, 1'b0, 1'b1);
    expect_eq("R4 unpriv hit deny", 64'(chk_deny_o), 64'h1);
    expect_eq("R5 ones fill", chk_rdata_o, '1);
    probe(32'h001F_FFFF, 1'b0, 1'b1);
    expect_eq("R4 top edge deny", 64'(chk_deny_o), 64'h1);
    probe(32'h0020_0000, 1'b0, 1'b1);
    expect_eq("R4 past edge allow", 64'(chk_deny_o), 64'h0);
    expect_eq("R5 pass data", chk_rdata_o, MEM);
    probe(32'h000F_FFFF, 1'b0, 1'b1);
    expect_eq("R4 below edge allow", 64'(chk_deny_o), 64'h0);
    probe(32'h0012_3456, 1'b1, 1'b1);
    expect_eq("R4 priv allow", 64'(chk_deny_o), 64'h0);
    expect_eq("R5 priv data", chk_rdata_o, MEM);
    probe(32'h0012_3456, 1'b0, 1'b0);
    expect_eq("R4 unpriv write deny", 64'(chk_deny_o), 64'h1);
    expect_eq("R5 write no fill", chk_rdata_o, MEM);
    expect_eq("R10 inside", 64'(hdl_outside_o), 64'h0);
    wr(3'd0, 64'h0030_0000, 1'b1);
    expect_eq("R10 outside", 64'(hdl_outside_o), 64'h1);
    wr(3'd2, 64'hFFF0_0001, 1'b1);
    probe(32'h0012_3456, 1'b0, 1'b1);
    expect_eq("R4 one bit inactive", 64'(chk_deny_o), 64'h0);
    expect_eq("R10 inactive", 64'(hdl_outside_o), 64'h0);
    wr(3'd2, 64'hFFF0_0003, 1'b1);
    wr(3'd0, 64'h0010_8000, 1'b1);
  endtask

  task automatic t_lock;
    logic [63:0] d;
    wr(3'd4, KEY_A, 1'b1);
    rd(3'd4, 1'b1, d);
    expect_eq("R6 key reads zero", d, 64'h0);
    wr(3'd3, 64'h1, 1'b1);
    expect_eq("R9 lock set", 64'(lock_o), 64'h1);
    wr(3'd1, 64'h0040_0000, 1'b1);
    wr(3'd2, 64'h0, 1'b1);
    wr(3'd0, 64'h0050_0000, 1'b1);
    rd(3'd1, 1'b1, d);
    expect_eq("R3 base frozen", d, 64'h0010_0000);
    rd(3'd0, 1'b1, d);
    expect_eq("R3 handler frozen", d, 64'h0010_8000);
    probe(32'h0012_3456, 1'b0, 1'b1);
    expect_eq("R3 mask frozen deny", 64'(chk_deny_o), 64'h1);
    wr(3'd3, 64'h0, 1'b1);
    expect_eq("R9 zero keeps lock", 64'(lock_o), 64'h1);
  endtask

  task automatic t_key;
    wr(3'd4, KEY_A ^ 64'h1, 1'b1);
    expect_eq("R8 miss pulse", 64'(key_miss_o), 64'h1);
    expect_eq("R8 lock kept", 64'(lock_o), 64'h1);
    @(negedge clk_i);
    expect_eq("R8 pulse one cycle", 64'(key_miss_o), 64'h0);
    wr(3'd4, KEY_A, 1'b0);
    expect_eq("R2 unpriv key ignored", 64'(lock_o), 64'h1);
    wr(3'd4, KEY_A, 1'b1);
    expect_eq("R7 unlock", 64'(lock_o), 64'h0);
    expect_eq("R7 no miss", 64'(key_miss_o), 64'h0);
    wr(3'd2, 64'h0, 1'b1);
    probe(32'h0012_3456, 1'b0, 1'b1);
    expect_eq("R7 regs writable again", 64'(chk_deny_o), 64'h0);
  endtask

  task automatic t_unarmed;
    do_reset();
    wr(3'd3, 64'h1, 1'b1);
    wr(3'd4, 64'h0, 1'b1);
    expect_eq("R8 unarmed miss", 64'(key_miss_o), 64'h1);
    expect_eq("R8 unarmed lock kept", 64'(lock_o), 64'h1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_priv_port();
    t_region();
    t_lock();
    t_key();
    t_unarmed();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule